// File: doc/BRIEF.md
# Tearing-Effect Synchronized Write Gate

This block sits between the source of display write requests and the engine that drives the display bus. It stops a new frame from going out to the panel until the panel's tearing-effect output shows a chosen edge. It can then hold off for a further programmable number of microseconds. The aim is to keep the write pointer into the panel's frame memory from crossing the panel's own read pointer. Only the first buffer of each frame is held back. The other buffers of the same frame are passed straight on, so a frame split into many buffers pays the synchronization cost once.

Each buffer is offered with `req_valid` together with a frame-end flag. The gate answers with a one-cycle grant pulse on `req_ready`, which also tells the bus engine to start. The bus engine reports the end of each buffer on `buf_done`. The gate drives the panel chip select (`cs_n`, active low). The select stays released while the gate waits, goes active when the first buffer of a frame is granted, and is held across every buffer of the frame until the last one completes. The tearing-effect input is asynchronous and passes through a two-flop synchronizer. A prescaler derived from the clock frequency parameter makes a one-microsecond tick for the delay counter.

Top module: `te_write_gate`

## Requirements
- R1: The sync mode is a 2-bit value. 0 means off, 1 means sync on the rising edge of the tearing-effect input, 2 means sync on its falling edge, and 3 is reserved and acts exactly like 0.
- R2: While reset is held and after it is released, `cs_n` is 1 and `req_ready` is 0. The latched mode resets to off.
- R3: With the sync mode off, a frame-start request presented at idle is granted after one clock edge, whatever the tearing-effect input does.
- R4: In rising-edge mode with delay D, the grant appears 3 + D*CLK_MHZ clock edges after the tearing-effect input rises. This counts 2 synchronizer stages, 1 edge-detect and decision edge, and D microsecond ticks.
- R5: In falling-edge mode, a rising edge does not release the gate. The grant appears 3 + D*CLK_MHZ edges after the input falls.
- R6: A delay of 0 gives the grant right after the edge, 3 clock edges after the input changes.
- R7: A request that follows a completed buffer whose frame-end flag was 0 is granted after one edge, with no wait for the tearing-effect input. A request after a buffer with the flag at 1 starts a new frame and waits again.
- R8: `cs_n` is 1 throughout the wait for the edge and the delay. It is 0 in the same cycle that `req_ready` pulses for a frame's first buffer. Each grant is a single-cycle pulse.
- R9: Once a frame starts, `cs_n` stays 0 across any later tearing-effect pulses and between buffers. It returns to 1 one edge after `buf_done` for the buffer whose frame-end flag was 1.
- R10: A tearing-effect edge that occurs before a frame-start request is pending is ignored. The gate waits for the next matching edge after the request.
- R11: Mode and delay are captured only when a frame-start request is accepted at idle. Changing them while a frame is pending or in progress has no effect until the next frame start.
- R12: The first request after reset is treated as a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| te_in | input | 1 | Asynchronous tearing-effect input from the panel |
| te_mode | input | 2 | Sync mode: 0 off, 1 rising, 2 falling, 3 reserved (off) |
| te_delay_us | input | DLY_W | Microseconds to wait after the edge |
| req_valid | input | 1 | Buffer write request, held until granted |
| req_frame_end | input | 1 | 1 when this buffer is the last of its frame |
| req_ready | output | 1 | One-cycle grant, also the start for the bus engine |
| buf_done | input | 1 | One-cycle pulse from the bus engine when a granted buffer has finished |
| cs_n | output | 1 | Panel chip select, active low |

## Verification
The hardest case to reach is a request that is already pending when the sync mode or delay is changed under it, while an edge of the wrong polarity passes by. The bench sets up this case directly. It arms the gate, rewrites the mode and delay, and toggles the tearing-effect input the wrong way. It then checks that no grant appears and that the grant delay still follows the values captured earlier. A second hard case is a frame made of several buffers with tearing-effect pulses landing between them. The bench interleaves `buf_done` pulses, mid-frame requests and input toggles. It checks that the mid-frame grants come at once and that chip select never releases before the last buffer.

// File: rtl/te_gate_pkg.sv
package te_gate_pkg;

  typedef enum logic [1:0] {
    TE_OFF  = 2'd0,
    TE_RISE = 2'd1,
    TE_FALL = 2'd2,
    TE_RSVD = 2'd3
  } te_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // no frame open, chip select released
    ST_ARM  = 3'd1,  // frame-start pending, watching for the edge
    ST_HOLD = 3'd2,  // edge seen, counting microseconds
    ST_BUSY = 3'd3,  // buffer granted, bus engine running
    ST_GAP  = 3'd4   // frame open, between buffers
  } gate_state_e;

  // True only for the modes that hold a frame start for an edge.
  function automatic logic mode_waits(input logic [1:0] m);
    return (m == TE_RISE) || (m == TE_FALL);
  endfunction

endpackage

// File: rtl/te_edge_detect.sv
module te_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic te_in,
  output logic rise,
  output logic fall
);
  localparam int LAST = SYNC_STAGES;

  // Stages 0..SYNC_STAGES-1 synchronize, stage SYNC_STAGES is the
  // one-cycle-old copy used for edge comparison.
  logic [LAST:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= te_in;
  end

  for (genvar i = 1; i <= LAST; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= 1'b0;
      else     chain[i] <= chain[i-1];
    end
  end

  assign rise =  chain[LAST-1] & ~chain[LAST];
  assign fall = ~chain[LAST-1] &  chain[LAST];

endmodule

// File: rtl/us_delay_timer.sv
module us_delay_timer #(
  parameter int CLK_MHZ = 250,
  parameter int DLY_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DLY_W-1:0] load,
  output logic             expire
);
  localparam int PRE_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_MHZ - 1);

  logic [PRE_W-1:0] pre;
  logic [DLY_W-1:0] remain;
  logic             running;
  logic             tick;

  assign tick   = (pre == PRE_LAST);
  assign expire = running && tick && (remain == DLY_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre     <= '0;
      remain  <= '0;
      running <= 1'b0;
    end else if (start) begin
      pre     <= '0;
      remain  <= load;
      running <= (load != '0);
    end else if (running) begin
      if (tick) begin
        pre    <= '0;
        remain <= remain - DLY_W'(1);
        if (remain == DLY_W'(1)) running <= 1'b0;
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end

endmodule

// File: rtl/te_gate_ctrl.sv
module te_gate_ctrl
  import te_gate_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_rise,
  input  logic             edge_fall,
  input  logic [1:0]       te_mode,
  input  logic [DLY_W-1:0] te_delay_us,
  input  logic             req_valid,
  input  logic             req_frame_end,
  input  logic             buf_done,
  input  logic             timer_expire,
  output logic             timer_start,
  output logic [DLY_W-1:0] timer_load,
  output logic             grant,
  output logic             cs_n,
  output gate_state_e      state
);
  gate_state_e      state_d;
  logic [1:0]       mode_q;
  logic [DLY_W-1:0] dly_q;
  logic             end_q;
  logic             grant_d;
  logic             capture;
  logic             hit;

  assign hit = ((mode_q == TE_RISE) && edge_rise) ||
               ((mode_q == TE_FALL) && edge_fall);

  assign timer_load = dly_q;

  always_comb begin
    state_d     = state;
    grant_d     = 1'b0;
    capture     = 1'b0;
    timer_start = 1'b0;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        capture = 1'b1;
        if (mode_waits(te_mode)) begin
          state_d = ST_ARM;
        end else begin
          grant_d = 1'b1;
          state_d = ST_BUSY;
        end
      end
      ST_ARM: if (hit) begin
        if (dly_q == '0) begin
          grant_d = 1'b1;
          state_d = ST_BUSY;
        end else begin
          timer_start = 1'b1;
          state_d     = ST_HOLD;
        end
      end
      ST_HOLD: if (timer_expire) begin
        grant_d = 1'b1;
        state_d = ST_BUSY;
      end
      ST_BUSY: if (buf_done) begin
        state_d = end_q ? ST_IDLE : ST_GAP;
      end
      ST_GAP: if (req_valid) begin
        grant_d = 1'b1;
        state_d = ST_BUSY;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      mode_q <= TE_OFF;
      dly_q  <= '0;
      end_q  <= 1'b0;
      grant  <= 1'b0;
      cs_n   <= 1'b1;
    end else begin
      state <= state_d;
      grant <= grant_d;
      cs_n  <= !((state_d == ST_BUSY) || (state_d == ST_GAP));
      if (capture) begin
        mode_q <= te_mode;
        dly_q  <= te_delay_us;
      end
      if (grant_d) end_q <= req_frame_end;
    end
  end

endmodule

// File: rtl/te_write_gate.sv
module te_write_gate
  import te_gate_pkg::*;
#(
  parameter int CLK_MHZ     = 250,
  parameter int DLY_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             te_in,
  input  logic [1:0]       te_mode,
  input  logic [DLY_W-1:0] te_delay_us,
  input  logic             req_valid,
  input  logic             req_frame_end,
  output logic             req_ready,
  input  logic             buf_done,
  output logic             cs_n
);
  logic             edge_rise;
  logic             edge_fall;
  logic             timer_start;
  logic             timer_expire;
  logic [DLY_W-1:0] timer_load;
  gate_state_e      gate_state;

  te_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .te_in (te_in),
    .rise  (edge_rise),
    .fall  (edge_fall)
  );

  us_delay_timer #(.CLK_MHZ(CLK_MHZ), .DLY_W(DLY_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (timer_start),
    .load   (timer_load),
    .expire (timer_expire)
  );

  te_gate_ctrl #(.DLY_W(DLY_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .edge_rise     (edge_rise),
    .edge_fall     (edge_fall),
    .te_mode       (te_mode),
    .te_delay_us   (te_delay_us),
    .req_valid     (req_valid),
    .req_frame_end (req_frame_end),
    .buf_done      (buf_done),
    .timer_expire  (timer_expire),
    .timer_start   (timer_start),
    .timer_load    (timer_load),
    .grant         (req_ready),
    .cs_n          (cs_n),
    .state         (gate_state)
  );

endmodule

// File: rtl/te_write_gate_chk.sv
module te_write_gate_chk
  import te_gate_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [1:0]  te_mode,
  input logic        req_valid,
  input logic        req_ready,
  input logic        buf_done,
  input logic        cs_n,
  input gate_state_e gate_state
);

  // R8
  grant_cs_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !cs_n);

  // R8
  wait_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_state == ST_ARM || gate_state == ST_HOLD) |-> cs_n);

  // R8
  grant_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);

  // R9
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> $past(buf_done));

  // R3
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_state == ST_IDLE && req_valid && !mode_waits(te_mode)) |=> req_ready);

  // R7
  midframe_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_state == ST_GAP && req_valid) |=> req_ready);

endmodule

bind te_write_gate te_write_gate_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .te_mode    (te_mode),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .buf_done   (buf_done),
  .cs_n       (cs_n),
  .gate_state (gate_state)
);

// File: tb/test_te_write_gate.sv
module test_te_write_gate;
  localparam int CLK_MHZ = 4;
  localparam int DLY_W   = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             te_in = 1'b0;
  logic [1:0]       te_mode = 2'd0;
  logic [DLY_W-1:0] te_delay_us = '0;
  logic             req_valid = 1'b0;
  logic             req_frame_end = 1'b0;
  logic             req_ready;
  logic             buf_done = 1'b0;
  logic             cs_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  te_write_gate #(.CLK_MHZ(CLK_MHZ), .DLY_W(DLY_W)) i_te_write_gate (
    .clk(clk), .rst(rst), .te_in(te_in), .te_mode(te_mode),
    .te_delay_us(te_delay_us), .req_valid(req_valid),
    .req_frame_end(req_frame_end), .req_ready(req_ready),
    .buf_done(buf_done), .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_te(input logic v);
    @(negedge clk);
    te_in = v;
  endtask

  task automatic post_req(input logic last);
    @(negedge clk);
    req_valid     = 1'b1;
    req_frame_end = last;
  endtask

  // Counts edges until a grant is seen; -1 if none within max.
  // Drops the request at the negedge after the grant.
  task automatic await_grant(input int max, output int n, output logic cs_at);
    n = -1;
    cs_at = 1'b1;
    for (int i = 1; i <= max; i++) begin
      @(posedge clk);
      #1;
      if (req_ready) begin
        n = i;
        cs_at = cs_n;
        break;
      end
    end
    if (n > 0) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic finish_buf();
    @(negedge clk);
    buf_done = 1'b1;
    @(negedge clk);
    buf_done = 1'b0;
  endtask

  task automatic t_reset();
    chk(cs_n == 1'b1, "R2 cs_n after reset", cs_n, 1);
    chk(req_ready == 1'b0, "R2 req_ready after reset", req_ready, 0);
  endtask

  task automatic t_first_rise();
    int n; logic c;
    te_mode = 2'd1; te_delay_us = '0;
    post_req(1'b1);
    await_grant(8, n, c);
    chk(n == -1, "R12 first request waits for edge", n, -1);
    chk(cs_n == 1'b1, "R8 cs_n released while waiting", cs_n, 1);
    set_te(1'b1);
    await_grant(20, n, c);
    chk(n == 3, "R6 zero delay latency", n, 3);
    chk(c == 1'b0, "R8 cs_n active with grant", c, 0);
    finish_buf();
    chk(cs_n == 1'b1, "R9 cs_n released after last buffer", cs_n, 1);
    set_te(1'b0);
    idle_cycles(4);
  endtask

  task automatic t_rise_delay();
    int n; logic c;
    int exp = 3 + 2 * CLK_MHZ;
    te_mode = 2'd1; te_delay_us = 8'd2;
    post_req(1'b1);
    idle_cycles(2);
    @(negedge clk);
    te_in = 1'b1;
    n = -1; c = 1'b1;
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk);
      #1;
      if (req_ready) begin n = i; c = cs_n; break; end
      if (cs_n != 1'b1) chk(1'b0, "R8 cs_n during delay", cs_n, 1);
    end
    @(negedge clk); req_valid = 1'b0;
    chk(n == exp, "R4 rising edge plus delay latency", n, exp);
    chk(c == 1'b0, "R8 cs_n at delayed grant", c, 0);
    finish_buf();
    set_te(1'b0);
    idle_cycles(4);
  endtask

  task automatic t_fall();
    int n; logic c;
    int exp = 3 + 1 * CLK_MHZ;
    te_mode = 2'd2; te_delay_us = 8'd1;
    post_req(1'b1);
    idle_cycles(2);
    set_te(1'b1);
    await_grant(12, n, c);
    chk(n == -1, "R5 rising edge ignored in falling mode", n, -1);
    set_te(1'b0);
    await_grant(30, n, c);
    chk(n == exp, "R5 falling edge plus delay latency", n, exp);
    finish_buf();
    idle_cycles(4);
  endtask

  task automatic t_off_modes();
    int n; logic c;
    te_mode = 2'd0;
    set_te(1'b1);
    post_req(1'b1);
    await_grant(10, n, c);
    chk(n == 1, "R3 off mode grants at once", n, 1);
    finish_buf();
    set_te(1'b0);
    te_mode = 2'd3;
    post_req(1'b1);
    await_grant(10, n, c);
    chk(n == 1, "R1 reserved mode acts as off", n, 1);
    chk(c == 1'b0, "R8 cs_n with bypass grant", c, 0);
    finish_buf();
    chk(cs_n == 1'b1, "R9 cs_n released in off mode", cs_n, 1);
    idle_cycles(4);
  endtask

  task automatic t_early_edge();
    int n; logic c;
    te_mode = 2'd1; te_delay_us = '0;
    set_te(1'b1);
    idle_cycles(6);
    post_req(1'b1);
    await_grant(20, n, c);
    chk(n == -1, "R10 edge before request ignored", n, -1);
    set_te(1'b0);
    await_grant(6, n, c);
    chk(n == -1, "R10 wrong polarity while armed", n, -1);
    set_te(1'b1);
    await_grant(20, n, c);
    chk(n == 3, "R10 next matching edge releases", n, 3);
    finish_buf();
    set_te(1'b0);
    idle_cycles(4);
  endtask

  task automatic t_midframe();
    int n; logic c;
    te_mode = 2'd1; te_delay_us = '0;
    post_req(1'b0);
    idle_cycles(2);
    set_te(1'b1);
    await_grant(20, n, c);
    chk(n == 3, "R7 frame start waits for edge", n, 3);
    set_te(1'b0);
    finish_buf();
    chk(cs_n == 1'b0, "R9 cs_n held between buffers", cs_n, 0);
    post_req(1'b0);
    await_grant(10, n, c);
    chk(n == 1, "R7 mid-frame buffer granted at once", n, 1);
    set_te(1'b1);
    idle_cycles(5);
    set_te(1'b0);
    idle_cycles(5);
    chk(cs_n == 1'b0, "R9 cs_n held across TE pulse", cs_n, 0);
    finish_buf();
    post_req(1'b1);
    await_grant(10, n, c);
    chk(n == 1, "R7 last buffer granted at once", n, 1);
    finish_buf();
    chk(cs_n == 1'b1, "R9 cs_n released at frame end", cs_n, 1);
    post_req(1'b1);
    await_grant(10, n, c);
    chk(n == -1, "R7 next frame waits again", n, -1);
    set_te(1'b1);
    await_grant(20, n, c);
    chk(n == 3, "R7 next frame released by edge", n, 3);
    finish_buf();
    set_te(1'b0);
    idle_cycles(4);
  endtask

  task automatic t_sampling();
    int n; logic c;
    te_mode = 2'd1; te_delay_us = '0;
    post_req(1'b1);
    idle_cycles(2);
    te_mode = 2'd0; te_delay_us = 8'd5;
    await_grant(10, n, c);
    chk(n == -1, "R11 mode change while armed ignored", n, -1);
    set_te(1'b1);
    await_grant(40, n, c);
    chk(n == 3, "R11 captured delay kept", n, 3);
    finish_buf();
    set_te(1'b0);
    idle_cycles(4);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_rise();
    t_rise_delay();
    t_fall();
    t_off_modes();
    t_early_edge();
    t_midframe();
    t_sampling();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule